// File: doc/BRIEF.md
# Signed Four-Operation Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two's-complement operands. A two-bit operation code picks one of four results: the bitwise complement of operand A, the sum A+B, the difference A−B, or twice A. The block also produces an overflow flag. That flag belongs only to the operation that is currently selected. Both operands and the result have the same width, which is a parameter with a default of 4 bits (value range −8 to +7).

The design is built from smaller parts:
- a gate-level one-bit full adder;
- a ripple-carry adder/subtractor that does both add and subtract on the same adder chain;
- a complement unit;
- a shift-based doubler with its own overflow logic;
- a four-input result multiplexer.

Addition and subtraction wrap modulo 2^W. The carry out of the top bit never reaches the result. The block has no clock; the result settles from the inputs within the same cycle.

Top module: `sgn_alu4`

## Requirements
- R1: Operation code 2'b00 drives the result with the bitwise complement of operand A.
- R2: Operation code 2'b01 drives the result with (A + B) modulo 2^W.
- R3: Operation code 2'b10 drives the result with (A − B) modulo 2^W. It is computed as A + ~B + 1 on the same adder chain.
- R4: Operation code 2'b11 drives the result with A shifted left by one bit, with a zero entering bit 0.
- R5: When adding, the overflow flag is 1 exactly when the signed sum of A and B lies outside the range −2^(W−1) to 2^(W−1)−1.
- R6: When subtracting, the overflow flag is 1 exactly when the signed difference A−B lies outside that range. For example, 0001 − 1000 overflows.
- R7: When doubling, the overflow flag is 1 exactly when the two most significant bits of A differ. For example, A=0100 gives 1000 with overflow.
- R8: When the complement operation is selected, the overflow flag is 0 for every operand value.
- R9: The carry out of the most significant bit is dropped. For example, 1111 + 0111 gives 0110 and no overflow.
- R10: The outputs depend only on the present inputs; no clock or stored state is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 00 complement, 01 add, 10 subtract, 11 double |
| opnd_a | input | W | Operand A, two's complement |
| opnd_b | input | W | Operand B, two's complement |
| result | output | W | Result of the selected operation |
| ovf | output | 1 | Signed overflow of the selected operation |

## Verification
The bench builds the default 4-bit instance. At this width, every combination of operation code and the two operands (1024 cases) can be applied, so each wrap and overflow boundary is covered exhaustively.

A second instance with W=6 receives seeded random stimulus. This shows that the carry chain, the overflow rules and the shift remain correct when the width is not 4.

Directed cases come first in the bench. They cover the most negative value, the dropped carry, and doubling across the sign boundary.

// File: rtl/sgn_alu_pkg.sv
package sgn_alu_pkg;

    localparam int ALU_W = 4;
    localparam int OP_W  = 2;
    localparam int N_OPS = 1 << OP_W;

    typedef enum logic [OP_W-1:0] {
        ALU_OP_NOT = 2'b00,
        ALU_OP_ADD = 2'b01,
        ALU_OP_SUB = 2'b10,
        ALU_OP_DBL = 2'b11
    } alu_op_e;

    // Subtract control for the shared adder chain
    function automatic logic op_is_sub(input alu_op_e op);
        return op == ALU_OP_SUB;
    endfunction

endpackage

// File: rtl/sgn_full_adder.sv
module sgn_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half_x;

    assign half_x = a_i ^ b_i;
    assign s_o    = half_x ^ c_i;
    assign c_o    = (a_i & b_i) | (c_i & half_x);

endmodule

// File: rtl/sgn_addsub.sv
module sgn_addsub #(
    parameter int W = sgn_alu_pkg::ALU_W
) (
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   carry;

    assign b_eff    = b_i ^ {W{sub_i}};
    assign carry[0] = sub_i;

    for (genvar i = 0; i < W; i++) begin : g_chain
        sgn_full_adder u_fa (
            .a_i (a_i[i]),
            .b_i (b_eff[i]),
            .c_i (carry[i]),
            .s_o (sum_o[i]),
            .c_o (carry[i+1])
        );
    end

    // Signed overflow from the last two carries; the top carry is otherwise dropped (R9)
    assign ovf_o = carry[W] ^ carry[W-1];

    // R5/R6: sign-rule view of overflow must agree with the carry view
    always_comb begin
        a_r5_r6_sign_rule: assert (ovf_o ==
            ((a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1])))
            else $error("adder overflow disagrees with sign rule");
    end

endmodule

// File: rtl/sgn_doubler.sv
module sgn_doubler #(
    parameter int W = sgn_alu_pkg::ALU_W
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] dbl_o,
    output logic         ovf_o
);
    assign dbl_o = {a_i[W-2:0], 1'b0};
    assign ovf_o = a_i[W-1] ^ a_i[W-2];

    // R7: overflow exactly when the shift changed the sign
    always_comb begin
        a_r7_dbl_sign: assert (ovf_o == (dbl_o[W-1] != a_i[W-1]))
            else $error("doubler overflow disagrees with sign change");
    end

endmodule

// File: rtl/sgn_mux4.sv
module sgn_mux4 #(
    parameter int W = sgn_alu_pkg::ALU_W
) (
    input  logic [1:0]        sel_i,
    input  logic [3:0][W-1:0] din_i,
    output logic [W-1:0]      dout_o
);
    logic [W-1:0] lo_pick;
    logic [W-1:0] hi_pick;

    assign lo_pick = sel_i[0] ? din_i[1] : din_i[0];
    assign hi_pick = sel_i[0] ? din_i[3] : din_i[2];
    assign dout_o  = sel_i[1] ? hi_pick  : lo_pick;

endmodule

// File: rtl/sgn_alu4.sv
module sgn_alu4 #(
    parameter int W = sgn_alu_pkg::ALU_W
) (
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         ovf
);
    import sgn_alu_pkg::*;

    alu_op_e           op;
    logic              sub_ctl;
    logic [W-1:0]      inv_val;
    logic [W-1:0]      as_val;
    logic              as_ovf;
    logic [W-1:0]      dbl_val;
    logic              dbl_ovf;
    logic [3:0][W-1:0] val_bus;
    logic [3:0][0:0]   ovf_bus;

    assign op      = alu_op_e'(op_sel);
    assign sub_ctl = op_is_sub(op);
    assign inv_val = ~opnd_a;

    sgn_addsub #(.W(W)) u_addsub (
        .sub_i (sub_ctl),
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .sum_o (as_val),
        .ovf_o (as_ovf)
    );

    sgn_doubler #(.W(W)) u_dbl (
        .a_i   (opnd_a),
        .dbl_o (dbl_val),
        .ovf_o (dbl_ovf)
    );

    assign val_bus = {dbl_val, as_val, as_val, inv_val};
    assign ovf_bus = {dbl_ovf, as_ovf, as_ovf, 1'b0};

    sgn_mux4 #(.W(W)) u_val_mux (
        .sel_i  (op_sel),
        .din_i  (val_bus),
        .dout_o (result)
    );

    sgn_mux4 #(.W(1)) u_ovf_mux (
        .sel_i  (op_sel),
        .din_i  (ovf_bus),
        .dout_o (ovf)
    );

    always_comb begin
        if (op == ALU_OP_NOT) begin
            a_r8_no_overflow: assert (!ovf) else $error("overflow on complement");
            a_r1_complement: assert ((result ^ opnd_a) == {W{1'b1}})
                else $error("complement result wrong");
        end
        if (op == ALU_OP_ADD) begin
            a_r2_add_sum: assert (W'(result - opnd_b) == opnd_a)
                else $error("sum result wrong");
        end
        if (op == ALU_OP_SUB) begin
            a_r3_sub_diff: assert (W'(result + opnd_b) == opnd_a)
                else $error("difference result wrong");
        end
        if (op == ALU_OP_DBL) begin
            a_r4_dbl_shift: assert ((result[W-1:1] == opnd_a[W-2:0]) && !result[0])
                else $error("double result wrong");
        end
    end

endmodule

// File: tb/sgn_alu4_bench.sv
module sgn_alu4_bench;

    localparam int WN = 4;
    localparam int WW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic [1:0]    op_n, op_w;
    logic [WN-1:0] a_n, b_n, y_n;
    logic [WW-1:0] a_w, b_w, y_w;
    logic          v_n, v_w;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    sgn_alu4 #(.W(WN)) u_sgn_alu4 (
        .op_sel(op_n), .opnd_a(a_n), .opnd_b(b_n), .result(y_n), .ovf(v_n));

    sgn_alu4 #(.W(WW)) u_sgn_alu4_wide (
        .op_sel(op_w), .opnd_a(a_w), .opnd_b(b_w), .result(y_w), .ovf(v_w));

    function automatic int to_signed(int w, int x);
        return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
    endfunction

    function automatic int exact_val(int w, int op, int a, int b);
        int sa = to_signed(w, a);
        int sb = to_signed(w, b);
        case (op)
            0: return -sa - 1;
            1: return sa + sb;
            2: return sa - sb;
            default: return 2 * sa;
        endcase
    endfunction

    function automatic int exp_res(int w, int op, int a, int b);
        return exact_val(w, op, a, b) & ((1 << w) - 1);
    endfunction

    function automatic int exp_ovf(int w, int op, int a, int b);
        int e = exact_val(w, op, a, b);
        if (op == 0) return 0;
        return (e > (1 << (w - 1)) - 1 || e < -(1 << (w - 1))) ? 1 : 0;
    endfunction

    function automatic string tag_res(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string tag_ovf(int op);
        case (op)
            0: return "R8";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, int got, int exp, string ctx);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, ctx, got, exp);
        end
    endtask

    task automatic run_narrow(int op, int a, int b, string extra);
        @(posedge clk);
        op_n = 2'(op); a_n = WN'(a); b_n = WN'(b);
        @(negedge clk);
        check({tag_res(op), extra}, int'(y_n), exp_res(WN, op, a, b),
              $sformatf("op=%0d a=%0d b=%0d result", op, a, b));
        check(tag_ovf(op), int'(v_n), exp_ovf(WN, op, a, b),
              $sformatf("op=%0d a=%0d b=%0d ovf", op, a, b));
    endtask

    task automatic run_wide(int op, int a, int b);
        @(posedge clk);
        op_w = 2'(op); a_w = WW'(a); b_w = WW'(b);
        @(negedge clk);
        check(tag_res(op), int'(y_w), exp_res(WW, op, a, b),
              $sformatf("W6 op=%0d a=%0d b=%0d result", op, a, b));
        check(tag_ovf(op), int'(v_w), exp_ovf(WW, op, a, b),
              $sformatf("W6 op=%0d a=%0d b=%0d ovf", op, a, b));
    endtask

    initial begin
        op_n = '0; a_n = '0; b_n = '0;
        op_w = '0; a_w = '0; b_w = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: all-zero inputs give the complement of zero with no clocked state
        check("R10", int'(y_n), 15, "idle result");
        check("R10", int'(v_n), 0, "idle ovf");

        // Directed corners
        run_narrow(1, 4'b1111, 4'b0111, "/R9");  // -1 + 7 = 6, carry dropped
        run_narrow(1, 4'b0110, 4'b0001, "");     // 6 + 1 = 7
        run_narrow(2, 4'b1111, 4'b1110, "");     // -1 - -2 = 1
        run_narrow(2, 4'b0001, 4'b1000, "");     // 1 - -8 overflows
        run_narrow(3, 4'b0100, 4'b0000, "");     // 4 * 2 overflows
        run_narrow(3, 4'b0011, 4'b0000, "");     // 3 * 2 = 6
        run_narrow(0, 4'b1101, 4'b0000, "");     // complement -> 0010
        run_narrow(1, 4'b1000, 4'b1000, "/R9");  // -8 + -8 wraps to 0

        // R10: combinational response, including changes between clock edges
        a_n = 4'd5; b_n = 4'd2; op_n = 2'b01;
        #1;
        check("R10", int'(y_n), 7, "mid-cycle sum");

        // Exhaustive at default width
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_narrow(op, a, b, "");

        // Seeded random on the wide instance
        void'($urandom(32'h5A17));
        for (int k = 0; k < 400; k++)
            run_wide(int'($urandom % 4), int'($urandom % 64), int'($urandom % 64));
        run_wide(1, 6'b100000, 6'b111111);  // -32 + -1 overflows
        run_wide(3, 6'b110000, 0);          // -16 * 2 = -32, no overflow

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule